// File: doc/BRIEF.md
# Stereo Frame-Sync Parallel Bridge

This block sits between a stereo converter pair and the rest of a chip, carrying 16-bit audio words over two parallel buses. A frame-sync clock at the sample rate, with a 50% duty cycle, marks which half of each frame belongs to which channel. The block runs on a master clock at 256 times the sample rate, and the two clocks share falling-edge alignment.

On the record side, internal logic supplies a left/right pair. After each frame-sync falling edge the outgoing bus carries the left word of that pair, and after the following rising edge it carries the right word of the same pair. On the playback side, the block samples the incoming bus once per half frame, in the last master-clock cycle of that half. It takes the left word from the low half and the right word from the high half, then presents both together as one aligned pair with a one-cycle strobe. A two-bit power-down code turns each direction off on its own, and a high reset clears the digital state.

Frame sync is treated as asynchronous. It passes through a synchronizer and an edge register. The playback bus is delayed by a matching number of stages, so the word that is captured belongs to the cycle just before the frame-sync edge.

Top module: `stereo_fs_bridge`

## Requirements
- R1: A frame-sync transition sampled at a master-clock edge shows at the outputs after the third rising edge counted from that one. Before that, the outputs keep their previous values.
- R2: On a frame-sync fall, the record bus takes the left input word and the block stores the right input word of the same instant.
- R3: On a frame-sync rise, the record bus takes the right word stored at the preceding fall, or zero if no fall has been seen since reset or power-up.
- R4: The playback left word is the bus value at the last master-clock edge that sampled frame sync low before it rose.
- R5: The playback right word is the bus value at the last master-clock edge that sampled frame sync high before it fell.
- R6: The playback pair outputs change only on a frame-sync fall. They change together, and the pair strobe is high for exactly one cycle, three edges after the fall is sampled.
- R7: Words pass through unchanged in bit order: bit 15 is the most significant bit and bit 0 the least, on all four buses.
- R8: Power-down code bit 0 turns the record direction off and bit 1 turns the playback direction off. So 00 is all on, 01 record off, 10 playback off, 11 both off.
- R9: While record is off, the record bus reads zero from the next cycle on, frame-sync edges are ignored, and the stored right word is cleared.
- R10: While playback is off, each word it captures is forced to zero. Pairs and their strobe are still produced.
- R11: Reset is active high. While it is high, the record bus, both playback words and the strobe read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock, 256 times the sample rate |
| rst | input | 1 | Active-high reset of the digital logic |
| fs_i | input | 1 | Frame sync: low half carries left, high half carries right |
| pwr_down_i | input | 2 | Power-down code; bit 0 record off, bit 1 playback off |
| adc_left_i | input | 16 | Left record word from internal logic |
| adc_right_i | input | 16 | Right record word from internal logic |
| adc_bus_o | output | 16 | Outgoing parallel record bus |
| dac_bus_i | input | 16 | Incoming parallel playback bus |
| dac_left_o | output | 16 | Captured playback left word |
| dac_right_o | output | 16 | Captured playback right word |
| dac_pair_o | output | 1 | One-cycle strobe when a new playback pair is presented |

## Verification
A synchronizer or edge register that is one stage off moves every output by a whole cycle. This shows within three master-clock cycles of the first frame-sync transition, both as a record-bus update at the wrong cycle and as a playback strobe at the wrong distance from the fall. A delay line of the wrong length swaps the captured playback word for a neighbouring one. The bench drives a different pattern in every other cycle of each half, so such a fault corrupts the very first pair. A right-word hold that is not cleared, or gating on the wrong power-down bit, appears as a non-zero word on the first event after a power transition.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RISE = 2'd1,
    EV_FALL = 2'd2
  } fs_event_t;

  typedef struct packed {
    logic dac_off;
    logic adc_off;
  } pd_mode_t;

  // Power-down code: bit 0 gates the record path, bit 1 the playback path.
  function automatic pd_mode_t decode_pd(input logic [1:0] code);
    pd_mode_t m;
    m.adc_off = code[0];
    m.dac_off = code[1];
    return m;
  endfunction

  // Classify a synchronized frame-sync level against its previous value.
  function automatic fs_event_t classify_edge(input logic now_lvl, input logic last_lvl);
    if (now_lvl && !last_lvl)      return EV_RISE;
    else if (!now_lvl && last_lvl) return EV_FALL;
    else                           return EV_NONE;
  endfunction

endpackage

// File: rtl/sfb_frame_sync.sv
module sfb_frame_sync
  import sfb_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fs_async,
  output fs_event_t evt_o
);

  logic [STAGES-1:0] chain;
  logic              prev_lvl;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      chain    <= '0;
      prev_lvl <= 1'b0;
    end else begin
      chain    <= {chain[STAGES-2:0], fs_async};
      prev_lvl <= chain[STAGES-1];
    end
  end

  assign evt_o = classify_edge(chain[STAGES-1], prev_lvl);

endmodule

// File: rtl/sfb_adc_tx.sv
module sfb_adc_tx
  import sfb_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adc_off,
  input  fs_event_t         evt,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic [WORD_W-1:0] bus_o
);

  logic [WORD_W-1:0] right_hold;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bus_o      <= '0;
      right_hold <= '0;
    end else if (adc_off) begin
      bus_o      <= '0;
      right_hold <= '0;
    end else begin
      case (evt)
        EV_FALL: begin
          bus_o      <= left_i;
          right_hold <= right_i;
        end
        EV_RISE: bus_o <= right_hold;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sfb_dac_rx.sv
module sfb_dac_rx
  import sfb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DELAY  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dac_off,
  input  fs_event_t         evt,
  input  logic [WORD_W-1:0] bus_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              pair_o
);

  // Delay line matching the frame-sync synchronizer plus its edge register.
  logic [WORD_W-1:0] pipe [DELAY];
  logic [WORD_W-1:0] word_in;
  logic [WORD_W-1:0] left_hold;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= bus_i;
  end

  for (genvar g = 1; g < DELAY; g++) begin : g_dly
    always_ff @(posedge clk or posedge rst) begin
      if (rst) pipe[g] <= '0;
      else     pipe[g] <= pipe[g-1];
    end
  end

  assign word_in = dac_off ? '0 : pipe[DELAY-1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      pair_o    <= 1'b0;
    end else begin
      pair_o <= 1'b0;
      case (evt)
        EV_RISE: left_hold <= word_in;
        EV_FALL: begin
          left_o  <= left_hold;
          right_o <= word_in;
          pair_o  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stereo_fs_bridge.sv
module stereo_fs_bridge
  import sfb_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_m,
  input  logic              rst,
  input  logic              fs_i,
  input  logic [1:0]        pwr_down_i,
  input  logic [WORD_W-1:0] adc_left_i,
  input  logic [WORD_W-1:0] adc_right_i,
  output logic [WORD_W-1:0] adc_bus_o,
  input  logic [WORD_W-1:0] dac_bus_i,
  output logic [WORD_W-1:0] dac_left_o,
  output logic [WORD_W-1:0] dac_right_o,
  output logic              dac_pair_o
);

  localparam int DAC_DELAY = SYNC_STAGES + 1;

  fs_event_t evt;
  pd_mode_t  pd;
  logic      fall_evt;
  logic      rise_evt;

  assign pd       = decode_pd(pwr_down_i);
  assign fall_evt = (evt == EV_FALL);
  assign rise_evt = (evt == EV_RISE);

  sfb_frame_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk_m),
    .rst      (rst),
    .fs_async (fs_i),
    .evt_o    (evt)
  );

  sfb_adc_tx #(
    .WORD_W (WORD_W)
  ) u_adc (
    .clk     (clk_m),
    .rst     (rst),
    .adc_off (pd.adc_off),
    .evt     (evt),
    .left_i  (adc_left_i),
    .right_i (adc_right_i),
    .bus_o   (adc_bus_o)
  );

  sfb_dac_rx #(
    .WORD_W (WORD_W),
    .DELAY  (DAC_DELAY)
  ) u_dac (
    .clk     (clk_m),
    .rst     (rst),
    .dac_off (pd.dac_off),
    .evt     (evt),
    .bus_i   (dac_bus_i),
    .left_o  (dac_left_o),
    .right_o (dac_right_o),
    .pair_o  (dac_pair_o)
  );

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        pwr_down_i,
  input logic [WORD_W-1:0] adc_bus_o,
  input logic [WORD_W-1:0] dac_left_o,
  input logic [WORD_W-1:0] dac_right_o,
  input logic              dac_pair_o,
  input logic              fall_evt,
  input logic              rise_evt
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (adc_bus_o == '0 && dac_left_o == '0 && dac_right_o == '0 && !dac_pair_o)); // R11

  AST_ADC_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i[0] |=> (adc_bus_o == '0)); // R9

  AST_ADC_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (!fall_evt && !rise_evt && !pwr_down_i[0]) |=> $stable(adc_bus_o)); // R1

  AST_PAIR_FROM_FALL: assert property (@(posedge clk) disable iff (rst)
    dac_pair_o |-> $past(fall_evt)); // R6

  AST_PAIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dac_pair_o |=> !dac_pair_o); // R6

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fall_evt |=> ($stable(dac_left_o) && $stable(dac_right_o))); // R6

  AST_DAC_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dac_pair_o && $past(pwr_down_i[1])) |-> (dac_right_o == '0)); // R10

endmodule

bind stereo_fs_bridge sfb_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk_m),
  .rst         (rst),
  .pwr_down_i  (pwr_down_i),
  .adc_bus_o   (adc_bus_o),
  .dac_left_o  (dac_left_o),
  .dac_right_o (dac_right_o),
  .dac_pair_o  (dac_pair_o),
  .fall_evt    (fall_evt),
  .rise_evt    (rise_evt)
);

// File: tb/stereo_fs_bridge_test.sv
module stereo_fs_bridge_test;

  localparam int W    = 16;
  localparam int HALF = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fs = 1'b0;
  logic [1:0]   pd = 2'b00;
  logic [W-1:0] adc_l = '0;
  logic [W-1:0] adc_r = '0;
  logic [W-1:0] dac_bus = '0;
  logic [W-1:0] adc_bus;
  logic [W-1:0] dac_l;
  logic [W-1:0] dac_r;
  logic         dac_pair;

  stereo_fs_bridge uut (
    .clk_m       (clk),
    .rst         (rst),
    .fs_i        (fs),
    .pwr_down_i  (pd),
    .adc_left_i  (adc_l),
    .adc_right_i (adc_r),
    .adc_bus_o   (adc_bus),
    .dac_bus_i   (dac_bus),
    .dac_left_o  (dac_l),
    .dac_right_o (dac_r),
    .dac_pair_o  (dac_pair)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W:0]     adc_q[$];   // bit W marks a rise event
  logic [2*W-1:0] dac_q[$];
  logic [W-1:0]   adc_now = '0;
  logic [W-1:0]   rh_model = '0;
  int             fall_cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a frame-sync level and push the record-bus value it must produce.
  task automatic toggle_fs(input logic lvl);
    fs = lvl;
    if (!lvl) begin
      fall_cyc = cyc;
      if (pd[0]) begin
        adc_q.push_back({1'b0, {W{1'b0}}});
        rh_model = '0;
      end else begin
        adc_q.push_back({1'b0, adc_l});
        rh_model = adc_r;
      end
    end else begin
      adc_q.push_back({1'b1, pd[0] ? {W{1'b0}} : rh_model});
    end
  endtask

  // One half frame: the real word sits only in the final slot, other slots carry its inverse.
  task automatic half(input logic [W-1:0] word, input logic lvl, input bit do_toggle,
                      input bit do_pd, input logic [1:0] pd_mid);
    for (int j = 0; j < HALF; j++) begin
      @(negedge clk);
      if (j == 0 && do_toggle) toggle_fs(lvl);
      dac_bus = (j == HALF-1) ? word : ~word;
      if (do_pd && j == HALF/2) begin
        pd = pd_mid;
        if (pd_mid[0]) rh_model = '0;
      end
      if (do_pd && j == HALF/2 + 1 && pd[0]) begin
        check(adc_bus == '0, "R8 R9 record off clears bus", adc_bus, 0);
        adc_now = '0;
      end
    end
  endtask

  task automatic frame(input logic [W-1:0] al, input logic [W-1:0] ar,
                       input logic [W-1:0] dl, input logic [W-1:0] dr,
                       input logic [1:0] pd_mid, input bit first);
    adc_l = al;
    adc_r = ar;
    half(dl, 1'b0, !first, 1'b1, pd_mid);
    half(dr, 1'b1, 1'b1, 1'b0, pd_mid);
    dac_q.push_back({pd[1] ? {W{1'b0}} : dl, pd[1] ? {W{1'b0}} : dr});
  endtask

  // Record-bus monitor: old value two cycles after a transition, new value on the third.
  initial begin
    forever begin
      logic [W:0] e;
      wait (adc_q.size() != 0);
      @(negedge clk);
      @(negedge clk);
      check(adc_bus == adc_now, "R1 bus unchanged before third edge", adc_bus, adc_now);
      @(negedge clk);
      e = adc_q.pop_front();
      if (e[W]) check(adc_bus == e[W-1:0], "R3 R7 right word on rise", adc_bus, e[W-1:0]);
      else      check(adc_bus == e[W-1:0], "R2 R7 left word on fall", adc_bus, e[W-1:0]);
      adc_now = e[W-1:0];
    end
  end

  // Playback monitor: compares every strobed pair with the expected queue.
  initial begin
    forever begin
      @(negedge clk);
      if (dac_pair && !rst) begin
        if (dac_q.size() == 0) begin
          check(1'b0, "R6 unexpected pair strobe", dac_pair, 0);
        end else begin
          logic [2*W-1:0] e;
          e = dac_q.pop_front();
          check(dac_l == e[2*W-1:W], "R4 R7 R10 left word", dac_l, e[2*W-1:W]);
          check(dac_r == e[W-1:0], "R5 R7 R10 right word", dac_r, e[W-1:0]);
          check(cyc - fall_cyc == 3, "R6 R1 pair latency", cyc - fall_cyc, 3);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    adc_l = 16'hFFFF;
    dac_bus = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(adc_bus == '0 && dac_l == '0 && dac_r == '0 && !dac_pair,
          "R11 outputs zero in reset", {adc_bus, dac_l}, 0);
    rst = 1'b0;
    adc_l = '0;
    @(negedge clk);
    check(adc_bus == '0 && !dac_pair, "R11 outputs zero after release", {adc_bus, 15'd0, dac_pair}, 0);

    frame(16'h1234, 16'hABCD, 16'h8001, 16'h7FFE, 2'b00, 1'b1);
    frame(16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000, 2'b00, 1'b0);
    frame(16'h0F0F, 16'hF0F0, 16'h00FF, 16'hFF00, 2'b01, 1'b0);  // record off mid-frame
    frame(16'h5555, 16'hAAAA, 16'h0001, 16'h8000, 2'b00, 1'b0);  // record back on
    frame(16'hC3C3, 16'h3C3C, 16'h1357, 16'h2468, 2'b00, 1'b0);
    frame(16'h4444, 16'h2222, 16'hDEAD, 16'hBEEF, 2'b10, 1'b0);  // playback off
    frame(16'h7777, 16'h9999, 16'hCAFE, 16'hF00D, 2'b11, 1'b0);  // both off
    frame(16'h0102, 16'h0304, 16'h0A0B, 16'h0C0D, 2'b00, 1'b0);
    frame(16'hFEDC, 16'h0123, 16'h6001, 16'h0006, 2'b00, 1'b0);

    @(negedge clk);
    adc_l = 16'h1111;
    adc_r = 16'h2222;
    toggle_fs(1'b0);
    repeat (12) @(negedge clk);
    check(adc_q.size() == 0 && dac_q.size() == 0, "R6 all expected items seen",
          adc_q.size() + dac_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule